// File: doc/BRIEF.md
# Converter Calibration Sequencer

This block is the digital control for the calibration of a sampling converter. It orders the calibration phases, drives a busy flag and gives an abstracted analog core one enable per phase: internal DAC trim, system gain trim and system offset trim. Each phase is a fixed number of clock cycles. A count register in the block times each phase. The trimming arithmetic sits outside this block.

A calibration begins on the rising edge of the active-low `cal_n` pulse, or on a one-cycle `sw_start` write. The falling edge of `cal_n` always returns the block to idle first. A two-bit mode input picks one of four variants. Full system calibration runs DAC and gain trim back to back. It then drops busy and waits for a rising edge on `convst`, which starts the offset trim. Gain-then-offset mode has the same pause but no DAC trim. The gain-only and offset-only modes run one phase and do not use `convst`.

States: IDLE, DAC (DAC trim), GAIN (gain trim), HOLD (busy low, waiting for the conversion-start edge), OFFS (offset trim). Transitions: IDLE→DAC (start, mode 0), IDLE→GAIN (start, mode 1 or 2), IDLE→OFFS (start, mode 3), DAC→GAIN (DAC timer expired), GAIN→HOLD (timer expired, mode 0 or 1), GAIN→IDLE (timer expired, mode 2), HOLD→OFFS (`convst` rising edge), OFFS→IDLE (timer expired), any→IDLE (`cal_n` falling edge).

Top module: `cal_sequencer`

## Requirements
- R1: While reset is applied and after it is released, `busy`, the three phase enables and `done` are all low.
- R2: A rising edge on `cal_n` in IDLE drives `busy` high on the third rising clock edge after the input changes: two for synchronization and one for the state register. A `sw_start` pulse in IDLE drives `busy` high after the next clock edge.
- R3: A falling edge on `cal_n` returns the block to IDLE from any state. `busy` is then low, no `done` is given, and a later `convst` edge does not start a phase.
- R4: Mode 0 (full system) runs `dac_cal_en` for DAC_CYC cycles, then `gain_cal_en` for GAIN_CYC cycles, with `busy` high for the whole time. `busy` then drops.
- R5: In modes 0 and 1, after the first part `busy` stays low with no enable active until a `convst` rising edge. That edge raises `busy` on the third clock edge and runs `offs_cal_en` for OFFS_CYC cycles.
- R6: Mode 1 (gain then offset) skips the DAC phase. Its first part is GAIN_CYC cycles of `gain_cal_en`.
- R7: Mode 2 runs only GAIN_CYC cycles of gain trim, and mode 3 runs only OFFS_CYC cycles of offset trim. Either one ends in IDLE without needing `convst`.
- R8: A `convst` rising edge while `busy` is high has no effect. Phase lengths do not change, and the pause that follows still waits for a new edge.
- R9: `done` is high for exactly one cycle, the last cycle of the final phase of the selected mode. `busy` is low on the next cycle. No `done` is given at the end of the first part of a two-part mode.
- R10: The mode is captured at the start. Changes to `mode` during a calibration have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; phase lengths count its cycles |
| rst_n | input | 1 | Asynchronous active-low reset |
| cal_n | input | 1 | Active-low calibration pulse; falling edge resets, rising edge starts |
| convst | input | 1 | Conversion-start input; its rising edge begins the offset part |
| mode | input | 2 | 0 full, 1 gain+offset, 2 gain only, 3 offset only |
| sw_start | input | 1 | One-cycle software start, accepted in IDLE |
| busy | output | 1 | High while a trim phase runs |
| dac_cal_en | output | 1 | Internal DAC trim phase active |
| gain_cal_en | output | 1 | System gain trim phase active |
| offs_cal_en | output | 1 | System offset trim phase active |
| done | output | 1 | One-cycle pulse at the end of the final phase |

## Verification
The assertions assume that `cal_n` and `convst` stay at each level for at least three clock cycles, so that every change passes through the synchronizer as one clean edge. They also assume that `sw_start` is pulsed only while the block is idle. The stimulus holds `cal_n` low for four cycles per pulse and holds each `convst` pulse for at least three cycles. It issues `sw_start` only after `busy` has been observed low. Random `convst` pulses during a phase are placed so that they are fully resolved before the phase ends.

// File: rtl/cal_seq_pkg.sv
package cal_seq_pkg;

    typedef enum logic [1:0] {
        MODE_FULL      = 2'd0,
        MODE_GAIN_OFFS = 2'd1,
        MODE_GAIN_ONLY = 2'd2,
        MODE_OFFS_ONLY = 2'd3
    } cal_mode_t;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_DAC  = 3'd1,
        ST_GAIN = 3'd2,
        ST_HOLD = 3'd3,
        ST_OFFS = 3'd4
    } cal_state_t;

    function automatic logic two_part(input cal_mode_t m);
        return (m == MODE_FULL) || (m == MODE_GAIN_OFFS);
    endfunction

endpackage

// File: rtl/sync_edge.sv
module sync_edge #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise,
    output logic fall
);
    logic [STAGES:0] shr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) shr <= {(STAGES+1){RST_VAL}};
        else        shr <= {shr[STAGES-1:0], din};
    end

    assign rise = shr[STAGES-1] & ~shr[STAGES];
    assign fall = ~shr[STAGES-1] & shr[STAGES];
endmodule

// File: rtl/phase_timer.sv
module phase_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] len,
    output logic             zero
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         cnt <= '0;
        else if (load)      cnt <= len - 1'b1;
        else if (cnt != '0) cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/cal_fsm.sv
module cal_fsm
    import cal_seq_pkg::*;
#(
    parameter int DAC_CYC  = 97215,
    parameter int GAIN_CYC = 13899,
    parameter int OFFS_CYC = 13899,
    parameter int CNT_W    = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cal_rise,
    input  logic             cal_fall,
    input  logic             cv_rise,
    input  logic             sw_start,
    input  logic [1:0]       mode,
    input  logic             tmr_zero,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_len,
    output logic             busy,
    output logic             dac_cal_en,
    output logic             gain_cal_en,
    output logic             offs_cal_en,
    output logic             done
);
    localparam logic [CNT_W-1:0] DAC_LEN  = CNT_W'(DAC_CYC);
    localparam logic [CNT_W-1:0] GAIN_LEN = CNT_W'(GAIN_CYC);
    localparam logic [CNT_W-1:0] OFFS_LEN = CNT_W'(OFFS_CYC);

    cal_state_t state, nxt;
    cal_mode_t  mode_q;
    logic       start;

    assign start = cal_rise | sw_start;

    always_comb begin
        nxt = state;
        if (cal_fall) begin
            nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE: if (start) begin
                    unique case (cal_mode_t'(mode))
                        MODE_FULL:      nxt = ST_DAC;
                        MODE_GAIN_OFFS: nxt = ST_GAIN;
                        MODE_GAIN_ONLY: nxt = ST_GAIN;
                        MODE_OFFS_ONLY: nxt = ST_OFFS;
                    endcase
                end
                ST_DAC:  if (tmr_zero) nxt = ST_GAIN;
                ST_GAIN: if (tmr_zero) nxt = two_part(mode_q) ? ST_HOLD : ST_IDLE;
                ST_HOLD: if (cv_rise)  nxt = ST_OFFS;
                ST_OFFS: if (tmr_zero) nxt = ST_IDLE;
                default: nxt = ST_IDLE;
            endcase
        end
    end

    always_comb begin
        tmr_load = (nxt != state) &&
                   (nxt == ST_DAC || nxt == ST_GAIN || nxt == ST_OFFS);
        tmr_len  = (nxt == ST_DAC)  ? DAC_LEN  :
                   (nxt == ST_GAIN) ? GAIN_LEN : OFFS_LEN;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            mode_q <= MODE_FULL;
        end else begin
            state <= nxt;
            if (state == ST_IDLE && start) mode_q <= cal_mode_t'(mode);
        end
    end

    always_comb begin
        dac_cal_en  = (state == ST_DAC);
        gain_cal_en = (state == ST_GAIN);
        offs_cal_en = (state == ST_OFFS);
        busy        = dac_cal_en | gain_cal_en | offs_cal_en;
        done        = !cal_fall && tmr_zero &&
                      ((state == ST_GAIN && !two_part(mode_q)) || state == ST_OFFS);
    end

    // R8
    gain_not_to_offs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_GAIN |=> state != ST_OFFS);

    // R6
    dac_only_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_DAC |-> mode_q == MODE_FULL);

    // R9
    done_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    // R5
    hold_waits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD && !cv_rise && !cal_fall) |=> state == ST_HOLD);

    // R3
    cal_fall_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cal_fall |=> (state == ST_IDLE && !busy));
endmodule

// File: rtl/cal_sequencer.sv
module cal_sequencer #(
    parameter int DAC_CYC     = 97215,
    parameter int GAIN_CYC    = 13899,
    parameter int OFFS_CYC    = 13899,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cal_n,
    input  logic       convst,
    input  logic [1:0] mode,
    input  logic       sw_start,
    output logic       busy,
    output logic       dac_cal_en,
    output logic       gain_cal_en,
    output logic       offs_cal_en,
    output logic       done
);
    localparam int MAX_AB = (DAC_CYC > GAIN_CYC) ? DAC_CYC : GAIN_CYC;
    localparam int MAX_CY = (MAX_AB > OFFS_CYC) ? MAX_AB : OFFS_CYC;
    localparam int CNT_W  = $clog2(MAX_CY + 1);
    localparam int N_IN   = 2;
    localparam logic [N_IN-1:0] IN_RST = 2'b01;

    logic [N_IN-1:0] raw_in, in_rise, in_fall;
    logic             tmr_load, tmr_zero;
    logic [CNT_W-1:0] tmr_len;

    assign raw_in = {convst, cal_n};

    for (genvar g = 0; g < N_IN; g++) begin : g_sync
        sync_edge #(.STAGES(SYNC_STAGES), .RST_VAL(IN_RST[g])) u_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (raw_in[g]),
            .rise (in_rise[g]),
            .fall (in_fall[g])
        );
    end

    phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .load (tmr_load),
        .len  (tmr_len),
        .zero (tmr_zero)
    );

    cal_fsm #(
        .DAC_CYC (DAC_CYC),
        .GAIN_CYC(GAIN_CYC),
        .OFFS_CYC(OFFS_CYC),
        .CNT_W   (CNT_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cal_rise   (in_rise[0]),
        .cal_fall   (in_fall[0]),
        .cv_rise    (in_rise[1]),
        .sw_start   (sw_start),
        .mode       (mode),
        .tmr_zero   (tmr_zero),
        .tmr_load   (tmr_load),
        .tmr_len    (tmr_len),
        .busy       (busy),
        .dac_cal_en (dac_cal_en),
        .gain_cal_en(gain_cal_en),
        .offs_cal_en(offs_cal_en),
        .done       (done)
    );
endmodule

// File: tb/test_cal_sequencer.sv
module test_cal_sequencer;
    localparam int DAC_C  = 40;
    localparam int GAIN_C = 12;
    localparam int OFFS_C = 9;

    logic clk = 1'b0, rst_n = 1'b0, cal_n = 1'b1, convst = 1'b0, sw_start = 1'b0;
    logic [1:0] mode = 2'd0;
    logic busy, dac_cal_en, gain_cal_en, offs_cal_en, done;
    int n_chk = 0, n_err = 0;

    always #2 clk = ~clk;

    cal_sequencer #(.DAC_CYC(DAC_C), .GAIN_CYC(GAIN_C), .OFFS_CYC(OFFS_C)) i_cal_sequencer (
        .clk(clk), .rst_n(rst_n), .cal_n(cal_n), .convst(convst), .mode(mode),
        .sw_start(sw_start), .busy(busy), .dac_cal_en(dac_cal_en),
        .gain_cal_en(gain_cal_en), .offs_cal_en(offs_cal_en), .done(done));

    function automatic int exp_dac(input int m);  return (m == 0) ? DAC_C : 0;  endfunction
    function automatic int exp_gain(input int m); return (m != 3) ? GAIN_C : 0; endfunction
    function automatic int exp_offs(input int m); return (m == 3) ? OFFS_C : 0; endfunction
    function automatic bit two_part(input int m); return m < 2;                 endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        summary();
    end

    // Edge on cal_n or convst: busy still low after two edges, high after the third (R2)
    task automatic wait_sync_start(input string req);
        @(negedge clk); @(negedge clk);
        check(busy == 1'b0, req, busy, 0);
        @(negedge clk);
        check(busy == 1'b1, req, busy, 1);
    endtask

    task automatic start_seq(input bit use_sw);
        if (use_sw) begin
            sw_start = 1'b1;
            @(negedge clk);
            sw_start = 1'b0;
            check(busy == 1'b1, "R2 sw", busy, 1);
        end else begin
            cal_n = 1'b0;
            repeat (4) @(negedge clk);
            check(busy == 1'b0, "R3 cal low idle", busy, 0);
            cal_n = 1'b1;
            wait_sync_start("R2 cal");
        end
    endtask

    task automatic measure(input bit inj_cv, input bit inj_mode,
                           output int nd, output int ng, output int no,
                           output int ndn, output bit last_done);
        int k = 0;
        nd = 0; ng = 0; no = 0; ndn = 0; last_done = 0;
        while (busy === 1'b1) begin
            nd += int'(dac_cal_en); ng += int'(gain_cal_en); no += int'(offs_cal_en);
            ndn += int'(done);
            last_done = done;
            k++;
            if (inj_cv && k == 2) convst = 1'b1;
            if (inj_cv && k == 5) convst = 1'b0;
            if (inj_mode && k == 1) mode = 2'($urandom() % 4);
            @(negedge clk);
        end
        convst = 1'b0;
    endtask

    task automatic finish_seq(input int m, input bit inj_cv, input bit inj_mode);
        int nd, ng, no, ndn; bit ld;
        measure(inj_cv, inj_mode, nd, ng, no, ndn, ld);
        check(nd == exp_dac(m),  (m == 0) ? "R4 dac len" : "R6 no dac", nd, exp_dac(m));
        check(ng == exp_gain(m), inj_mode ? "R10 gain len" : "R7 gain len", ng, exp_gain(m));
        check(no == exp_offs(m), inj_cv ? "R8 offs len" : "R7 offs len", no, exp_offs(m));
        check(ndn == (two_part(m) ? 0 : 1), "R9 done count", ndn, two_part(m) ? 0 : 1);
        check(ld == !two_part(m) && done == 1'b0, "R9 done last", ld, !two_part(m));
        if (two_part(m)) begin
            repeat (3 + $urandom() % 8) @(negedge clk);
            check(!busy && !dac_cal_en && !gain_cal_en && !offs_cal_en,
                  inj_cv ? "R8 hold" : "R5 hold", busy, 0);
            convst = 1'b1;
            wait_sync_start("R5 convst");
            measure(1'b0, 1'b0, nd, ng, no, ndn, ld);
            check(no == OFFS_C && nd == 0 && ng == 0, "R5 offs len", no, OFFS_C);
            check(ndn == 1 && ld, "R9 done final", ndn, 1);
        end
    endtask

    task automatic abort_and_restart(input int m);
        int dn = 0;
        cal_n = 1'b0;
        repeat (3) @(negedge clk);
        check(busy == 1'b0, "R3 abort busy", busy, 0);
        repeat (4) begin
            convst = 1'b1;
            dn += int'(done) + int'(busy);
            @(negedge clk);
        end
        convst = 1'b0;
        repeat (4) begin dn += int'(done) + int'(busy); @(negedge clk); end
        check(dn == 0, "R3 stays idle", dn, 0);
        mode = 2'(m);
        cal_n = 1'b1;
        wait_sync_start("R3 restart");
        finish_seq(m, 1'b0, 1'b0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check(!busy && !dac_cal_en && !gain_cal_en && !offs_cal_en && !done,
              "R1 in reset", busy, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(!busy && !done, "R1 after reset", busy, 0);

        // directed: each mode once from a cal pulse
        for (int m = 0; m < 4; m++) begin
            mode = 2'(m);
            start_seq(1'b0);
            finish_seq(m, 1'b0, 1'b0);
            repeat (3) @(negedge clk);
        end

        // abort during the DAC phase, then restart full mode
        mode = 2'd0;
        start_seq(1'b1);
        repeat (3) @(negedge clk);
        abort_and_restart(0);
        repeat (3) @(negedge clk);

        // abort during the hold of gain+offset mode: convst must not start
        mode = 2'd1;
        start_seq(1'b1);
        begin
            int nd, ng, no, ndn; bit ld;
            measure(1'b0, 1'b0, nd, ng, no, ndn, ld);
            check(ng == GAIN_C && nd == 0, "R6 gain first", ng, GAIN_C);
        end
        abort_and_restart(3);
        repeat (3) @(negedge clk);

        // random mix
        for (int i = 0; i < 40; i++) begin
            int m = int'($urandom() % 4);
            bit sw = 1'($urandom() % 2);
            bit cv = 1'($urandom() % 2);
            bit mm = 1'($urandom() % 2);
            mode = 2'(m);
            start_seq(sw);
            finish_seq(m, cv, mm);
            repeat (2 + $urandom() % 4) @(negedge clk);
        end

        summary();
    end
endmodule